// File: doc/BRIEF.md
# Debug Breakpoint Status Unit

This block watches the memory accesses and control events of a processor core and records why the single debug exception was raised. It holds four breakpoint slots. Each slot has a linear address, a length qualifier and an access-type qualifier. Every access presented to the block is compared against all enabled slots at once. Every hit, and every other debug event, sets its own sticky flag in one status word. Because all causes share one exception vector, the handler reads this word to find out what happened.

Besides the address matches, the block records three more causes: a single-step trap, a switch into a task whose trap bit is set, and an attempt to touch a debug register while register guarding is on. Each event raises a one-cycle fault or trap request in the cycle after it occurs. Faults come from fetch breakpoints and guarded-register attempts, which are reported before the instruction runs. Traps come from data breakpoints, single-step and task switches, which are reported after the instruction completes. Software loads the slots through a small configuration port and overwrites the status word through a write port.

Top module: `dbg_status_unit`

## Requirements
- R1: When `cfgWrEn` is high at a clock edge, slot `cfgIdx` takes `cfgAddr`, `cfgLen`, `cfgType` and `cfgEnable`. The other slots keep their contents.
- R2: A slot covers 1 byte (`cfgLen`=00), 2 bytes (01) or 4 bytes (1x), starting at its address with the low 0, 1 or 2 bits cleared. An access covers 1 byte (`accSize`=00), 2 bytes (01) or 4 bytes (1x), starting at `accAddr`. The access matches the slot when any of its bytes lies in the slot's range.
- R3: Slot type 00 matches only fetches (`accKind`=00). Type 01 matches only data writes (`accKind`=01). Type 11 matches data reads (`accKind`=10) and data writes. Type 10 never matches.
- R4: A slot whose enable bit is 0 never sets its flag, and neither does any access while `accValid` is 0. On a match, flag bit i of `status` (bits 3..0) is set at the next edge.
- R5: `dregAccess` while `guardDetect` is 1 sets `status[4]` and raises `excFault` in the next cycle. With `guardDetect` at 0 it has no effect.
- R6: `instrDone` while `stepFlag` is 1 sets `status[5]` and raises `excTrap` in the next cycle.
- R7: `taskSwitch` with `taskTrapBit` at 1 sets `status[6]` and raises `excTrap` in the next cycle. With `taskTrapBit` at 0 it has no effect.
- R8: Status bits are sticky. Hardware never clears them. `statWrEn` replaces the word with `statWrData`, and any bit set by an event in that same cycle still ends up 1.
- R9: `excFault` is high for the cycle after a fetch breakpoint match or a guarded access. `excTrap` is high for the cycle after a data breakpoint match, a single-step event or a trapped task switch. Both are low otherwise.
- R10: While `rstN` is low, every slot is disabled and `status`, `excFault` and `excTrap` are 0.
- R11: Causes that occur in the same cycle are all recorded together, and both `excFault` and `excTrap` may be high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load one breakpoint slot |
| cfgIdx | input | 2 | Slot to load |
| cfgAddr | input | 32 | Breakpoint linear address |
| cfgLen | input | 2 | Breakpoint length code |
| cfgType | input | 2 | Breakpoint access-type code |
| cfgEnable | input | 1 | Slot enable |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 32 | Access linear address |
| accSize | input | 2 | Access size code |
| accKind | input | 2 | 00 fetch, 01 write, 10 read |
| stepFlag | input | 1 | Trap flag of the running code |
| instrDone | input | 1 | An instruction completed this cycle |
| taskSwitch | input | 1 | A task switch happened this cycle |
| taskTrapBit | input | 1 | Trap bit of the incoming task |
| dregAccess | input | 1 | An instruction tries to access a debug register |
| guardDetect | input | 1 | Debug-register guarding is on |
| statWrEn | input | 1 | Software write of the status word |
| statWrData | input | 7 | Value written to the status word |
| status | output | 7 | {BT, BS, BD, B3, B2, B1, B0} sticky cause flags |
| excFault | output | 1 | Debug fault request |
| excTrap | output | 1 | Debug trap request |

## Verification
Two kinds of collision matter in this block. The first is a software write to the status word in the same cycle as a hardware cause. The bench provokes it by random write pulses laid over random events, and in one directed cycle by clearing the word while a breakpoint hits. A bit whose cause fires in that cycle must end up set, and every other bit must take the written value. The second is a fault cause meeting trap causes in one cycle. A directed cycle fires a guarded access, a data hit, a step and a trapped task switch together, and expects four flags plus both requests in the next cycle.

// File: rtl/dbg_status_pkg.sv
package dbg_status_pkg;
  localparam int NUM_BP = 4;
  localparam int STAT_W = NUM_BP + 3;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_READ  = 2'b10
  } acc_kind_e;

  typedef struct packed {
    logic [NUM_BP-1:0] load;
  } dbg_strobe_t;
endpackage

// File: rtl/dbg_match_dp.sv
module dbg_match_dp
  import dbg_status_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbg_strobe_t       stb,
  input  logic [AW-1:0]     cfgAddr,
  input  logic [1:0]        cfgLen,
  input  logic [1:0]        cfgType,
  input  logic              cfgEnable,
  input  logic              accValid,
  input  logic [AW-1:0]     accAddr,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accKind,
  output logic [NUM_BP-1:0] hit
);
  logic [AW:0] accStart, accEnd;

  always_comb begin
    accStart = {1'b0, accAddr};
    case (accSize)
      2'b00:   accEnd = accStart;
      2'b01:   accEnd = accStart + (AW+1)'(1);
      default: accEnd = accStart + (AW+1)'(3);
    endcase
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    logic [AW-1:0] base;
    logic [1:0]    lenCode, typeCode;
    logic          en;
    logic [AW-1:0] spanMask;
    logic [AW:0]   bpStart, bpEnd;
    logic          overlap, typeOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        base     <= '0;
        lenCode  <= '0;
        typeCode <= '0;
        en       <= 1'b0;
      end else if (stb.load[i]) begin
        base     <= cfgAddr;
        lenCode  <= cfgLen;
        typeCode <= cfgType;
        en       <= cfgEnable;
      end
    end

    always_comb begin
      case (lenCode)
        2'b00:   spanMask = AW'(0);
        2'b01:   spanMask = AW'(1);
        default: spanMask = AW'(3);
      endcase
      bpStart = {1'b0, base & ~spanMask};
      bpEnd   = bpStart + {1'b0, spanMask};
      overlap = (accStart <= bpEnd) && (bpStart <= accEnd);
      case (typeCode)
        2'b00:   typeOk = (accKind == KIND_FETCH);
        2'b01:   typeOk = (accKind == KIND_WRITE);
        2'b11:   typeOk = (accKind == KIND_WRITE) || (accKind == KIND_READ);
        default: typeOk = 1'b0;
      endcase
      hit[i] = accValid && en && overlap && typeOk;
    end
  end
endmodule

// File: rtl/dbg_status_ctl.sv
module dbg_status_ctl
  import dbg_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgIdx,
  output dbg_strobe_t       stb,
  input  logic [NUM_BP-1:0] hit,
  input  logic [1:0]        accKind,
  input  logic              stepFlag,
  input  logic              instrDone,
  input  logic              taskSwitch,
  input  logic              taskTrapBit,
  input  logic              dregAccess,
  input  logic              guardDetect,
  input  logic              statWrEn,
  input  logic [STAT_W-1:0] statWrData,
  output logic [STAT_W-1:0] status,
  output logic              excFault,
  output logic              excTrap
);
  logic stepEvt, taskEvt, guardEvt, anyHit, fetchHit;
  logic [STAT_W-1:0] setBits, baseBits;

  always_comb begin
    stb.load = '0;
    if (cfgWrEn) stb.load[cfgIdx] = 1'b1;
  end

  always_comb begin
    stepEvt  = stepFlag && instrDone;
    taskEvt  = taskSwitch && taskTrapBit;
    guardEvt = dregAccess && guardDetect;
    anyHit   = |hit;
    fetchHit = anyHit && (accKind == KIND_FETCH);
    setBits  = {taskEvt, stepEvt, guardEvt, hit};
    baseBits = statWrEn ? statWrData : status;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status   <= '0;
      excFault <= 1'b0;
      excTrap  <= 1'b0;
    end else begin
      status   <= baseBits | setBits;
      excFault <= fetchHit || guardEvt;
      excTrap  <= (anyHit && !fetchHit) || stepEvt || taskEvt;
    end
  end
endmodule

// File: rtl/dbg_status_unit.sv
module dbg_status_unit
  import dbg_status_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgIdx,
  input  logic [AW-1:0]     cfgAddr,
  input  logic [1:0]        cfgLen,
  input  logic [1:0]        cfgType,
  input  logic              cfgEnable,
  input  logic              accValid,
  input  logic [AW-1:0]     accAddr,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accKind,
  input  logic              stepFlag,
  input  logic              instrDone,
  input  logic              taskSwitch,
  input  logic              taskTrapBit,
  input  logic              dregAccess,
  input  logic              guardDetect,
  input  logic              statWrEn,
  input  logic [STAT_W-1:0] statWrData,
  output logic [STAT_W-1:0] status,
  output logic              excFault,
  output logic              excTrap
);
  dbg_strobe_t       stb;
  logic [NUM_BP-1:0] hit;

  dbg_match_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgType(cfgType), .cfgEnable(cfgEnable),
    .accValid(accValid), .accAddr(accAddr), .accSize(accSize), .accKind(accKind),
    .hit(hit)
  );

  dbg_status_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .stb(stb),
    .hit(hit), .accKind(accKind),
    .stepFlag(stepFlag), .instrDone(instrDone),
    .taskSwitch(taskSwitch), .taskTrapBit(taskTrapBit),
    .dregAccess(dregAccess), .guardDetect(guardDetect),
    .statWrEn(statWrEn), .statWrData(statWrData),
    .status(status), .excFault(excFault), .excTrap(excTrap)
  );
endmodule

// File: rtl/dbg_status_chk.sv
module dbg_status_chk
  import dbg_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              stepFlag,
  input logic              instrDone,
  input logic              taskSwitch,
  input logic              taskTrapBit,
  input logic              dregAccess,
  input logic              guardDetect,
  input logic              statWrEn,
  input logic [STAT_W-1:0] status,
  input logic              excFault,
  input logic              excTrap
);
  // R5: guarded register attempt gives flag and fault
  assert_guard_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dregAccess && guardDetect) |=> (status[4] && excFault));

  // R6: single-step gives flag and trap
  assert_step_trap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stepFlag && instrDone) |=> (status[5] && excTrap));

  // R7: trapped task switch gives flag and trap
  assert_task_trap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (taskSwitch && taskTrapBit) |=> (status[6] && excTrap));

  // R8: without a software write, no flag ever drops
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !statWrEn |=> ((status & $past(status)) == $past(status)));

  // R9: a fault request always comes with a fault-class flag recorded
  assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    excFault |-> (|status[4:0]));
endmodule

bind dbg_status_unit dbg_status_chk u_chk (
  .clk(clk), .rstN(rstN), .stepFlag(stepFlag), .instrDone(instrDone),
  .taskSwitch(taskSwitch), .taskTrapBit(taskTrapBit),
  .dregAccess(dregAccess), .guardDetect(guardDetect),
  .statWrEn(statWrEn), .status(status), .excFault(excFault), .excTrap(excTrap)
);

// File: tb/sim_dbg_status_unit.sv
module sim_dbg_status_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgEnable = 0, accValid = 0, stepFlag = 0, instrDone = 0;
  logic taskSwitch = 0, taskTrapBit = 0, dregAccess = 0, guardDetect = 0, statWrEn = 0;
  logic [1:0] cfgIdx = 0, cfgLen = 0, cfgType = 0, accSize = 0, accKind = 0;
  logic [31:0] cfgAddr = 0, accAddr = 0;
  logic [6:0] statWrData = 0;
  logic [6:0] status;
  logic excFault, excTrap;

  int checks = 0, errors = 0;
  bit finished = 0;

  dbg_status_unit u0 (.*);

  // reference model state
  longint mBase [4];
  int     mLen [4], mType [4];
  bit     mEn [4];
  logic [6:0] eStat = 0;
  logic eFault = 0, eTrap = 0;

  function automatic bit modelHit(int i);
    int n, m;
    longint a;
    if (!mEn[i] || !accValid) return 0;
    case (mType[i])
      0: if (accKind != 2'd0) return 0;
      1: if (accKind != 2'd1) return 0;
      3: if (accKind != 2'd1 && accKind != 2'd2) return 0;
      default: return 0;
    endcase
    n = (accSize == 0) ? 1 : (accSize == 1) ? 2 : 4;
    m = (mLen[i] == 0) ? 0 : (mLen[i] == 1) ? 1 : 3;
    for (int j = 0; j < n; j++) begin
      a = longint'(accAddr) + j;
      if ((a & ~longint'(m)) == (mBase[i] & ~longint'(m))) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mEn[i] <= 0;
      eStat <= 0; eFault <= 0; eTrap <= 0;
    end else begin
      logic [6:0] s;
      bit anyFetch, anyData, g, st, tk;
      s = statWrEn ? statWrData : eStat;
      anyFetch = 0; anyData = 0;
      for (int i = 0; i < 4; i++)
        if (modelHit(i)) begin
          s[i] = 1'b1;
          if (accKind == 2'd0) anyFetch = 1; else anyData = 1;
        end
      g  = dregAccess && guardDetect;
      st = stepFlag && instrDone;
      tk = taskSwitch && taskTrapBit;
      if (g)  s[4] = 1'b1;
      if (st) s[5] = 1'b1;
      if (tk) s[6] = 1'b1;
      eStat  <= s;
      eFault <= anyFetch || g;
      eTrap  <= anyData || st || tk;
      if (cfgWrEn) begin
        mBase[cfgIdx] <= longint'(cfgAddr);
        mLen[cfgIdx]  <= int'(cfgLen);
        mType[cfgIdx] <= int'(cfgType);
        mEn[cfgIdx]   <= cfgEnable;
      end
    end
  end

  task automatic compareAll(string tag);
    checks++;
    if (status[3:0] !== eStat[3:0]) begin
      errors++;
      $display("FAIL %s R1 R2 R3 R4 R8 breakpoint flags: got %b exp %b", tag, status[3:0], eStat[3:0]);
    end
    checks++;
    if (status[6:4] !== eStat[6:4]) begin
      errors++;
      $display("FAIL %s R5 R6 R7 R8 event flags: got %b exp %b", tag, status[6:4], eStat[6:4]);
    end
    checks++;
    if (excFault !== eFault || excTrap !== eTrap) begin
      errors++;
      $display("FAIL %s R9 requests fault/trap: got %b%b exp %b%b", tag, excFault, excTrap, eFault, eTrap);
    end
  endtask

  task automatic idleIn();
    cfgWrEn = 0; accValid = 0; stepFlag = 0; instrDone = 0; taskSwitch = 0;
    taskTrapBit = 0; dregAccess = 0; guardDetect = 0; statWrEn = 0;
  endtask

  task automatic stepCycle(string tag);
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic loadSlot(int idx, int addr, int len, int typ, bit en);
    idleIn();
    cfgWrEn = 1; cfgIdx = 2'(idx); cfgAddr = 32'(addr);
    cfgLen = 2'(len); cfgType = 2'(typ); cfgEnable = en;
    stepCycle("R1 load");
  endtask

  task automatic directCheck(string tag, logic [6:0] expS, logic expF, logic expT);
    checks++;
    if (status !== expS || excFault !== expF || excTrap !== expT) begin
      errors++;
      $display("FAIL %s: got %b %b%b exp %b %b%b", tag, status, excFault, excTrap, expS, expF, expT);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idleIn();
    repeat (3) @(negedge clk);
    directCheck("R10 reset state", 7'b0, 1'b0, 1'b0);
    rstN = 1;
    @(negedge clk);

    // R2 R3: 2-byte write breakpoint at 0x12, 4-byte write hits 0x10..0x13
    loadSlot(0, 'h13, 1, 1, 1);
    idleIn(); accValid = 1; accAddr = 'h10; accSize = 2'b11; accKind = 2'd1;
    stepCycle("R2 overlap");
    directCheck("R2 R9 data hit slot0", 7'b000_0001, 1'b0, 1'b1);
    // R3: read to same place does not hit a write-only slot
    idleIn(); statWrEn = 1; statWrData = 0; stepCycle("R8 clear");
    idleIn(); accValid = 1; accAddr = 'h12; accSize = 0; accKind = 2'd2;
    stepCycle("R3 read miss");
    directCheck("R3 read ignored by write slot", 7'b0, 1'b0, 1'b0);
    // R9: fetch slot gives fault
    loadSlot(2, 'h40, 0, 0, 1);
    idleIn(); accValid = 1; accAddr = 'h40; accSize = 0; accKind = 2'd0;
    stepCycle("R9 fetch");
    directCheck("R9 fetch fault slot2", 7'b000_0100, 1'b1, 1'b0);
    // R4: disabled slot never hits
    loadSlot(2, 'h40, 0, 0, 0);
    idleIn(); statWrEn = 1; statWrData = 0; stepCycle("R8 clear");
    idleIn(); accValid = 1; accAddr = 'h40; accKind = 2'd0;
    stepCycle("R4 disabled");
    directCheck("R4 disabled slot", 7'b0, 1'b0, 1'b0);
    // R7: task switch without trap bit ignored; R5 without guard ignored
    idleIn(); taskSwitch = 1; dregAccess = 1; stepCycle("R7 R5 ignored");
    directCheck("R7 R5 untrapped events ignored", 7'b0, 1'b0, 1'b0);
    // R11 + R8: all causes together while software clears
    loadSlot(1, 'h20, 1, 3, 1);
    idleIn(); accValid = 1; accAddr = 'h21; accSize = 0; accKind = 2'd1;
    stepFlag = 1; instrDone = 1; taskSwitch = 1; taskTrapBit = 1;
    dregAccess = 1; guardDetect = 1; statWrEn = 1; statWrData = 7'b000_1000;
    stepCycle("R11 combined");
    directCheck("R11 R8 all causes, write overlaid", 7'b111_1010, 1'b1, 1'b1);
    idleIn(); stepCycle("R8 hold");
    directCheck("R8 sticky hold", 7'b111_1010, 1'b0, 1'b0);

    // random phase, model compared each cycle
    for (int k = 0; k < 4000; k++) begin
      idleIn();
      if ($urandom % 8 == 0) begin
        cfgWrEn = 1; cfgIdx = 2'($urandom); cfgAddr = 32'($urandom % 64);
        cfgLen = 2'($urandom); cfgType = 2'($urandom); cfgEnable = ($urandom % 4) != 0;
      end
      accValid = ($urandom % 4) != 0;
      accAddr = 32'($urandom % 64); accSize = 2'($urandom); accKind = 2'($urandom % 3);
      stepFlag = ($urandom % 8 == 0); instrDone = $urandom;
      taskSwitch = ($urandom % 10 == 0); taskTrapBit = $urandom;
      dregAccess = ($urandom % 10 == 0); guardDetect = $urandom;
      statWrEn = ($urandom % 6 == 0); statWrData = 7'($urandom);
      stepCycle("random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule